// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block sits between a serial port's register interface and its four modem handshake outputs and four modem handshake inputs. A small control register holds the host's wishes for the two handshake outputs, the two auxiliary outputs and a self-test loopback switch. All outgoing pins are active low. The four incoming pins are active low and asynchronous. Each one passes through a two-flop synchronizer and is then shown to the host as an active-high level.

A status word combines the four current input levels with four sticky change flags. Three of these flags record any change of carrier detect, data set ready or clear to send. The fourth records only the end of a ring. Reading the status word returns it and clears the flags in the same cycle. A change that arrives in the read cycle is kept. Whenever a flag becomes newly set, a one-cycle event pulse goes out so that a status reporter can send the word upstream.

In loopback, the outgoing pins are parked inactive (high) and the external inputs are ignored. Each control bit then drives the status level of its partner input.

Top module: `modem_ctl_stat`

## Requirements
- R1: The control register resets to 0. A write stores bits 4:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback), and the new value is visible on `ctl_rd_data` after the write edge. Bits 7:5 always read 0.
- R2: Outside loopback, a control bit of 1 drives its pin low and a 0 drives it high. The mapping is DTR→`dtr_n`, RTS→`rts_n`, OUT1→`out1_n`, OUT2→`out2_n`. After reset all four pins are high.
- R3: Status bits 7:4 show the asserted level of DCD, RI, DSR and CTS. Bit 7 is DCD and bit 4 is CTS, and a bit is 1 when its pin is low. A pin change reaches the status word after the second rising clock edge that follows it, and not after the first.
- R4: Status bits 3, 1 and 0 are set by any change of DCD, DSR and CTS respectively. Each stays set through further changes until a read clears it.
- R5: Status bit 2 is set only when RI goes from asserted to deasserted (`ri_n` low to high). RI becoming asserted leaves the bit clear.
- R6: A cycle with `stat_rd_en` high returns the current status word and clears bits 3:0 at the next edge. A change that is detected in that same cycle leaves its flag set.
- R7: `stat_change` pulses high for one cycle, at the edge where a flag becomes set from the clear state or is set again during a read. It does not pulse for changes while the flag is already set.
- R8: With loopback set, all four outgoing pins are high. The status levels then follow the control bits: RTS→CTS, DTR→DSR, OUT1→RI, OUT2→DCD.
- R9: With loopback set, the external input pins have no effect on the status word.
- R10: After reset the status word reads 0x00 and `stat_change` is low, while all input pins are idle (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value |
| ctl_rd_data | output | 8 | Control register read-back |
| stat_rd_en | input | 1 | Status read strobe (clears change flags) |
| stat_rd_data | output | 8 | Status word: levels 7:4, change flags 3:0 |
| stat_change | output | 1 | One-cycle pulse when a change flag is newly set |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | Auxiliary output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |

## Verification
The properties assume that each input pin holds a new level for several clocks, so that every change shows up as one clean step after the synchronizer. They also assume that the read strobe is a host access and not tied high. The stimulus holds every pin level for at least four cycles. It raises the read strobe for single cycles only, and it places one read deliberately in the cycle where a synchronized change lands, to test the collision case. The loopback vectors change the external pins while loopback is on and then return the pins to idle before loopback is left, so that the comparison starts from a known pipeline.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    // positions inside the four-line input vector and the status nibbles
    localparam int LINE_CTS = 0;
    localparam int LINE_DSR = 1;
    localparam int LINE_RI  = 2;
    localparam int LINE_DCD = 3;
    localparam int N_LINES  = 4;

    // control register layout; packed order gives bit 4..0
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_word_t;

    localparam int CTL_BITS = $bits(ctl_word_t);
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int         WIDTH   = 4,
    parameter int         STAGES  = 2,
    parameter logic [0:0] RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef logic [WIDTH-1:0] vec_t;
    localparam vec_t RST_VEC = {WIDTH{RST_VAL}};

    vec_t stg_d [STAGES];
    vec_t stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VEC;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
    import mdm_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_word_t        ctl_o,
    output logic [REG_W-1:0] rd_data,
    output logic [3:0]       pins_n      // {out2, out1, rts, dtr}
);
    localparam int PAD_W = REG_W - CTL_BITS;

    typedef struct packed {
        ctl_word_t ctl;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.ctl = ctl_word_t'(wr_data[CTL_BITS-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o   = s_q.ctl;
    assign rd_data = {{PAD_W{1'b0}}, s_q.ctl};

    // loopback parks every pin inactive; otherwise a 1 pulls the pin low
    always_comb begin
        if (s_q.ctl.loop) pins_n = 4'b1111;
        else              pins_n = ~{s_q.ctl.out2, s_q.ctl.out1,
                                     s_q.ctl.rts,  s_q.ctl.dtr};
    end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] ext_lvl,   // synchronized, active high
    input  ctl_word_t          ctl,
    input  logic               rd_en,
    output logic [REG_W-1:0]   rd_data,
    output logic               change_o
);
    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] delta;
        logic               change;
    } state_t;

    state_t s_d, s_q;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] loop_lvl;
    logic [N_LINES-1:0] evt;

    // fixed crossover used in loopback
    always_comb begin
        loop_lvl[LINE_CTS] = ctl.rts;
        loop_lvl[LINE_DSR] = ctl.dtr;
        loop_lvl[LINE_RI]  = ctl.out1;
        loop_lvl[LINE_DCD] = ctl.out2;
    end

    assign lvl = ctl.loop ? loop_lvl : ext_lvl;

    always_comb begin
        evt[LINE_CTS] = lvl[LINE_CTS] ^ s_q.prev[LINE_CTS];
        evt[LINE_DSR] = lvl[LINE_DSR] ^ s_q.prev[LINE_DSR];
        evt[LINE_DCD] = lvl[LINE_DCD] ^ s_q.prev[LINE_DCD];
        evt[LINE_RI]  = s_q.prev[LINE_RI] & ~lvl[LINE_RI];   // ring end only

        s_d        = s_q;
        s_d.prev   = lvl;
        s_d.delta  = (rd_en ? '0 : s_q.delta) | evt;
        s_d.change = |(evt & (rd_en ? {N_LINES{1'b1}} : ~s_q.delta));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data  = {lvl, s_q.delta};
    assign change_o = s_q.change;

    assert_delta_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ((s_q.delta & $past(s_q.delta)) == $past(s_q.delta)));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ((s_q.delta & ~$past(evt)) == '0));

    assert_no_teri_on_ring_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl[LINE_RI]) && !rd_en && !s_q.delta[LINE_RI]) |=> !s_q.delta[LINE_RI]);

    assert_change_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.change |-> (s_q.delta != '0));
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mdm_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [REG_W-1:0] ctl_wr_data,
    output logic [REG_W-1:0] ctl_rd_data,
    input  logic             stat_rd_en,
    output logic [REG_W-1:0] stat_rd_data,
    output logic             stat_change,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             out1_n,
    output logic             out2_n,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             dcd_n
);
    ctl_word_t          ctl;
    logic [3:0]         pins_n;
    logic [N_LINES-1:0] raw_n;
    logic [N_LINES-1:0] sync_n;

    always_comb begin
        raw_n[LINE_CTS] = cts_n;
        raw_n[LINE_DSR] = dsr_n;
        raw_n[LINE_RI]  = ri_n;
        raw_n[LINE_DCD] = dcd_n;
    end

    mdm_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_n),
        .sync_o  (sync_n)
    );

    mdm_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ctl_o   (ctl),
        .rd_data (ctl_rd_data),
        .pins_n  (pins_n)
    );

    mdm_status #(.REG_W(REG_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_lvl  (~sync_n),
        .ctl      (ctl),
        .rd_en    (stat_rd_en),
        .rd_data  (stat_rd_data),
        .change_o (stat_change)
    );

    assign {out2_n, out1_n, rts_n, dtr_n} = pins_n;

    assert_ctl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (ctl_rd_data[CTL_BITS-1:0] == $past(ctl_wr_data[CTL_BITS-1:0])));

    assert_pins_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[CTL_BITS-1] |-> ({dtr_n, rts_n, out1_n, out2_n} == 4'b1111));
endmodule

// File: tb/sim_modem_ctl_stat.sv
`timescale 1ns/1ps
module sim_modem_ctl_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = '0;
    logic [7:0] ctl_rd_data;
    logic       stat_rd_en = 1'b0;
    logic [7:0] stat_rd_data;
    logic       stat_change;
    logic       dtr_n, rts_n, out1_n, out2_n;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    modem_ctl_stat u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .stat_rd_en(stat_rd_en), .stat_rd_data(stat_rd_data), .stat_change(stat_change),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n)
    );

    // {ctl write, pins {dcd_n,ri_n,dsr_n,cts_n}, expected status, expected {out2_n,out1_n,rts_n,dtr_n}}
    localparam logic [23:0] VEC [9] = '{
        {8'h00, 4'hF, 8'h00, 4'hF},   // idle                         R2 R3
        {8'h03, 4'hE, 8'h11, 4'hC},   // DTR/RTS on, CTS asserted     R2 R3 R4
        {8'h0C, 4'h5, 8'hAB, 4'h3},   // OUT1/OUT2, DCD+DSR, CTS drop R4
        {8'h00, 4'h1, 8'hE0, 4'hF},   // ring starts: no flag         R5
        {8'h00, 4'h5, 8'hA4, 4'hF},   // ring ends: trailing flag     R5
        {8'hFF, 4'hF, 8'hF1, 4'hF},   // loopback, all controls on    R8 R1
        {8'h15, 4'h0, 8'h69, 4'hF},   // loopback, pins ignored       R8 R9
        {8'h11, 4'hF, 8'h24, 4'hF},   // loopback OUT1 off: ring end  R8 R5
        {8'h00, 4'hF, 8'h02, 4'hF}    // leave loopback               R8
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read();
        @(negedge clk) stat_rd_en = 1'b1;
        @(negedge clk) stat_rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        // R10 R1 R2: reset state
        chk("R10 status after reset", stat_rd_data, 8'h00);
        chk("R10 change after reset", {7'd0, stat_change}, 8'h00);
        chk("R1 control after reset", ctl_rd_data, 8'h00);
        chk("R2 pins during reset", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 status after release", stat_rd_data, 8'h00);

        // table walk
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            {dcd_n, ri_n, dsr_n, cts_n} = VEC[i][15:12];
            ctl_wr_data = VEC[i][23:16];
            ctl_wr_en = 1'b1;
            @(negedge clk) ctl_wr_en = 1'b0;
            repeat (6) @(negedge clk);
            chk("R3/R4/R5/R8/R9 status word", stat_rd_data, VEC[i][11:4]);
            chk("R2/R8 output pins", {4'd0, out2_n, out1_n, rts_n, dtr_n}, {4'd0, VEC[i][3:0]});
            chk("R1 control read-back", ctl_rd_data, VEC[i][23:16] & 8'h1F);
            do_read();
        end
        repeat (3) @(negedge clk);
        chk("R6 flags cleared by read", stat_rd_data, 8'h00);

        // R3: two-edge latency, then R7 single pulse
        @(negedge clk) cts_n = 1'b0;
        @(negedge clk);
        chk("R3 not visible after one edge", stat_rd_data, 8'h00);
        @(negedge clk);
        chk("R3 visible after two edges", stat_rd_data, 8'h10);
        @(negedge clk);
        chk("R7 pulse on new flag", {7'd0, stat_change}, 8'h01);
        chk("R4 CTS flag set", stat_rd_data, 8'h11);
        @(negedge clk);
        chk("R7 pulse lasts one cycle", {7'd0, stat_change}, 8'h00);
        // R4/R7: second change while flag set
        cts_n = 1'b1;
        pulses = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (stat_change) pulses++;
        end
        chk("R7 no pulse while flag set", pulses[7:0], 8'h00);
        chk("R4 flag sticky over two changes", stat_rd_data, 8'h01);
        do_read();
        @(negedge clk);

        // R4: DSR toggles twice before a read
        dsr_n = 1'b0;
        repeat (4) @(negedge clk);
        dsr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 DSR flag after double change", stat_rd_data, 8'h02);
        do_read();
        @(negedge clk);

        // R6: read in the cycle the synchronized change lands
        cts_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) stat_rd_en = 1'b1;
        chk("R6 read returns current word", stat_rd_data, 8'h10);
        @(negedge clk) stat_rd_en = 1'b0;
        chk("R6 collision keeps new flag", stat_rd_data, 8'h11);
        chk("R7 pulse on re-set during read", {7'd0, stat_change}, 8'h01);
        do_read();
        @(negedge clk);
        chk("R6 plain read clears", stat_rd_data, 8'h10);
        cts_n = 1'b1;
        repeat (5) @(negedge clk);
        do_read();
        @(negedge clk);
        chk("R10 back to idle", stat_rd_data, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule